// File: doc/BRIEF.md
# Interlace-Aware Video Timing Generator

This block produces horizontal sync, vertical sync and data enable for a video transmitter, together with the current pixel position, line position and field identifier. Software supplies the active width and height, the horizontal and vertical blanking lengths, the distance from the start of blanking to the sync pulse, and the sync pulse widths. Each line and each field starts with blanking and ends with active video. The blanking length is front porch plus sync plus back porch, and the sync offset equals the front porch.

In interlaced mode every vertical value is given per field, which is half of the frame value. The field identifier toggles when the line counter wraps, that is, at the start of each field's vertical blanking. In the odd field the vertical sync pulse is shifted by half a line. When the frame's total vertical blanking is odd, a blanking-oscillation flag gives the odd field one extra blanking line, so that the two fields together reproduce the frame exactly. Each of the three sync and enable outputs has its own polarity bit, and a mode flag that selects between HDMI and DVI signalling is passed through unchanged for downstream logic.

The horizontal part is a state machine with the states H_IDLE, H_FRONT, H_SYNC, H_BACK and H_ACT. The vertical part uses V_IDLE, V_FRONT, V_SYNC, V_BACK and V_ACT. Both machines enter their IDLE state whenever enable is low. On the first enabled edge they leave IDLE for the state of position zero, which is H_FRONT, or H_SYNC when the sync offset is zero. They then move in order FRONT to SYNC to BACK to ACT as the position crosses each programmed boundary, and they return from ACT to the first state at the wrap. A state whose length is zero is skipped. The vertical machine changes state only at line starts.

Top module: `vid_timing_gen`

## Requirements
- R1: After reset, and while enable is low, the pixel and line counters read 0, the field identifier reads 0, and hsync, vsync and data enable sit at their inactive levels.
- R2: With enable high, the pixel counter shows 0 on the first enabled cycle. It then counts up to h_blank+h_active-1 and wraps to 0. The line counter shows 0 on the first enabled cycle, advances by one at each pixel wrap, and wraps after the last line of the field.
- R3: Hsync is active for the pixel positions from h_sync_off up to, but not including, h_sync_off+h_sync_wid.
- R4: Data enable is active only when the pixel counter is at least h_blank and the line counter is at least the blanking length of the current field.
- R5: In progressive mode, and in field 0 of interlaced mode, vsync is active for whole lines from v_sync_off up to, but not including, v_sync_off+v_sync_wid. It starts and ends at pixel 0.
- R6: In interlaced mode the field identifier toggles each time the line counter wraps to 0. In progressive mode it is 0.
- R7: In field 1 of interlaced mode, vsync starts and ends at pixel floor((h_blank+h_active)/2) of the lines v_sync_off and v_sync_off+v_sync_wid.
- R8: With interlace and blanking oscillation both set, field 1 has v_blank+1 blanking lines and field 0 has v_blank. Without interlace, the oscillation flag has no effect.
- R9: Each of the hsync, vsync and data-enable polarity bits selects active high when 1 and active low when 0, independently of the other two.
- R10: The HDMI/DVI mode output always equals the mode configuration input.
- R11: If enable is low at a rising edge, both counters and the field identifier are 0 after that edge. When enable returns high, timing restarts at pixel 0, line 0, field 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low holds the generator at the start of blanking |
| cfg_h_active | input | 13 | Active pixels per line |
| cfg_h_blank | input | 13 | Horizontal blanking pixels |
| cfg_h_sync_off | input | 13 | Pixels from the start of blanking to the start of hsync |
| cfg_h_sync_wid | input | 10 | Hsync width in pixels |
| cfg_v_active | input | 13 | Active lines per field |
| cfg_v_blank | input | 8 | Vertical blanking lines per field |
| cfg_v_sync_off | input | 8 | Lines from the start of blanking to the start of vsync |
| cfg_v_sync_wid | input | 6 | Vsync width in lines |
| cfg_hs_pol | input | 1 | Hsync polarity, 1 = active high |
| cfg_vs_pol | input | 1 | Vsync polarity, 1 = active high |
| cfg_de_pol | input | 1 | Data-enable polarity, 1 = active high |
| cfg_interlace | input | 1 | Interlaced output |
| cfg_vblank_osc | input | 1 | Field 1 gets one extra blanking line (interlaced only) |
| cfg_hdmi_mode | input | 1 | HDMI/DVI mode flag |
| hsync | output | 1 | Horizontal sync at the programmed polarity |
| vsync | output | 1 | Vertical sync at the programmed polarity |
| de | output | 1 | Data enable at the programmed polarity |
| field_id | output | 1 | Current field |
| pix_cnt | output | 14 | Pixel position in the line, blanking first |
| line_cnt | output | 14 | Line position in the field, blanking first |
| hdmi_mode | output | 1 | Copy of cfg_hdmi_mode |

## Verification
The counters, the field identifier and the sync and enable outputs all change on the same rising edge. That edge is the first enabled one for the starting position (0,0), and the first edge with enable low for the return to zero. The mode flag follows its input with no clock at all. The bench therefore advances its own position model once per rising edge and compares every output at the following falling edge, so each result is read in the cycle it is due. Vsync in field 1 is predicted from a linear pixel index that is offset by half a line. This is a different formulation from the two update points the design uses, so an error in the half-line position shows up directly.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    typedef enum logic [2:0] {
        H_IDLE, H_FRONT, H_SYNC, H_BACK, H_ACT
    } hphase_t;

    typedef enum logic [2:0] {
        V_IDLE, V_FRONT, V_SYNC, V_BACK, V_ACT
    } vphase_t;
endpackage

// File: rtl/vtg_line_fsm.sv
module vtg_line_fsm
    import vtg_pkg::*;
#(
    parameter int HAW  = 13,
    parameter int HSWW = 10,
    localparam int PW  = HAW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [HAW-1:0]  h_active,
    input  logic [HAW-1:0]  h_blank,
    input  logic [HAW-1:0]  h_sync_off,
    input  logic [HSWW-1:0] h_sync_wid,
    output logic [PW-1:0]   hpos,
    output logic [PW-1:0]   half_pos,
    output logic            h_idle,
    output logic            line_begin,
    output logic            half_hit,
    output logic            hs_act,
    output logic            h_in_act
);
    hphase_t       phase, phase_nxt;
    logic [PW-1:0] htot, sync_end, hpos_nxt;
    logic          last;

    always_comb begin
        htot     = PW'(h_blank) + PW'(h_active);
        sync_end = PW'(h_sync_off) + PW'(h_sync_wid);
        half_pos = htot >> 1;
        last     = (hpos == htot - PW'(1));
        if (!en || phase == H_IDLE || last) hpos_nxt = '0;
        else                                hpos_nxt = hpos + PW'(1);
        if (!en)                               phase_nxt = H_IDLE;
        else if (hpos_nxt < PW'(h_sync_off))   phase_nxt = H_FRONT;
        else if (hpos_nxt < sync_end)          phase_nxt = H_SYNC;
        else if (hpos_nxt < PW'(h_blank))      phase_nxt = H_BACK;
        else                                   phase_nxt = H_ACT;
        line_begin = en && (hpos_nxt == '0);
        half_hit   = en && (phase != H_IDLE) && (hpos_nxt == half_pos);
        h_idle     = (phase == H_IDLE);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= H_IDLE;
            hpos  <= '0;
        end else begin
            phase <= phase_nxt;
            hpos  <= hpos_nxt;
        end
    end

    // outputs
    always_comb begin
        hs_act   = 1'b0;
        h_in_act = 1'b0;
        unique case (phase)
            H_IDLE:  ;
            H_FRONT: ;
            H_SYNC:  hs_act = 1'b1;
            H_BACK:  ;
            H_ACT:   h_in_act = 1'b1;
        endcase
    end

    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en && phase != H_IDLE && hpos == htot - PW'(1)) |=> (hpos == '0));
    a_r2_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != H_IDLE) |-> (hpos < htot));
    a_r3_sync_window: assert property (@(posedge clk) disable iff (!rst_n)
        hs_act |-> (hpos >= PW'(h_sync_off) && hpos < sync_end));
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (hpos == '0 && phase == H_IDLE));
endmodule

// File: rtl/vtg_field_fsm.sv
module vtg_field_fsm
    import vtg_pkg::*;
#(
    parameter int VAW  = 13,
    parameter int VBW  = 8,
    parameter int VSWW = 6,
    parameter int PW   = 14,
    localparam int LW  = VAW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [VAW-1:0]  v_active,
    input  logic [VBW-1:0]  v_blank,
    input  logic [VBW-1:0]  v_sync_off,
    input  logic [VSWW-1:0] v_sync_wid,
    input  logic            interlace,
    input  logic            osc,
    input  logic            h_idle,
    input  logic            line_begin,
    input  logic            half_hit,
    input  logic [PW-1:0]   hpos,
    input  logic [PW-1:0]   half_pos,
    output logic [LW-1:0]   vpos,
    output logic            field,
    output logic            vs_act,
    output logic            v_in_act
);
    vphase_t       vphase, vphase_nxt;
    logic [LW-1:0] vpos_nxt, vb_cur, vb_nxt, vtot, vs_start, vs_end;
    logic          field_nxt, vs_nxt;

    always_comb begin
        vs_start = LW'(v_sync_off);
        vs_end   = LW'(v_sync_off) + LW'(v_sync_wid);
        vb_cur   = LW'(v_blank) + LW'(interlace & osc & field);
        vtot     = vb_cur + LW'(v_active);
        vpos_nxt  = vpos;
        field_nxt = field;
        if (!en || (line_begin && h_idle)) begin
            vpos_nxt  = '0;
            field_nxt = 1'b0;
        end else if (line_begin) begin
            if (vpos == vtot - LW'(1)) begin
                vpos_nxt  = '0;
                field_nxt = interlace ? ~field : 1'b0;
            end else begin
                vpos_nxt = vpos + LW'(1);
            end
        end
        vb_nxt = LW'(v_blank) + LW'(interlace & osc & field_nxt);
        if (!en)                          vphase_nxt = V_IDLE;
        else if (!line_begin)             vphase_nxt = vphase;
        else if (vpos_nxt < vs_start)     vphase_nxt = V_FRONT;
        else if (vpos_nxt < vs_end)       vphase_nxt = V_SYNC;
        else if (vpos_nxt < vb_nxt)       vphase_nxt = V_BACK;
        else                              vphase_nxt = V_ACT;
        // field 0 samples the sync window at line start, field 1 at mid-line
        if (!en)
            vs_nxt = 1'b0;
        else if (line_begin && !field_nxt)
            vs_nxt = (vpos_nxt >= vs_start) && (vpos_nxt < vs_end);
        else if (half_hit && field)
            vs_nxt = (vpos >= vs_start) && (vpos < vs_end);
        else
            vs_nxt = vs_act;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vphase <= V_IDLE;
            vpos   <= '0;
            field  <= 1'b0;
            vs_act <= 1'b0;
        end else begin
            vphase <= vphase_nxt;
            vpos   <= vpos_nxt;
            field  <= field_nxt;
            vs_act <= vs_nxt;
        end
    end

    // outputs
    always_comb begin
        v_in_act = 1'b0;
        unique case (vphase)
            V_IDLE:  ;
            V_FRONT: ;
            V_SYNC:  ;
            V_BACK:  ;
            V_ACT:   v_in_act = 1'b1;
        endcase
    end

    a_r5_even_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vs_act) && !field) |-> (hpos == '0));
    a_r7_odd_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(vs_act) && field && !$changed(field)) |-> (hpos == half_pos));
    a_r8_long_field: assert property (@(posedge clk) disable iff (!rst_n)
        (en && line_begin && !h_idle && interlace && osc && field &&
         vpos == LW'(v_blank) + LW'(v_active) - LW'(1))
        |=> (vpos == LW'(v_blank) + LW'(v_active)));
    a_r11_field_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!field && vpos == '0 && !vs_act));
endmodule

// File: rtl/vtg_polarity.sv
module vtg_polarity #(
    parameter int N = 3
) (
    input  logic [N-1:0] act,
    input  logic [N-1:0] pol,
    output logic [N-1:0] lvl
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        assign lvl[i] = act[i] ~^ pol[i];
    end
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen #(
    parameter int HAW  = 13,
    parameter int HSWW = 10,
    parameter int VAW  = 13,
    parameter int VBW  = 8,
    parameter int VSWW = 6,
    localparam int PW  = HAW + 1,
    localparam int LW  = VAW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [HAW-1:0]  cfg_h_active,
    input  logic [HAW-1:0]  cfg_h_blank,
    input  logic [HAW-1:0]  cfg_h_sync_off,
    input  logic [HSWW-1:0] cfg_h_sync_wid,
    input  logic [VAW-1:0]  cfg_v_active,
    input  logic [VBW-1:0]  cfg_v_blank,
    input  logic [VBW-1:0]  cfg_v_sync_off,
    input  logic [VSWW-1:0] cfg_v_sync_wid,
    input  logic            cfg_hs_pol,
    input  logic            cfg_vs_pol,
    input  logic            cfg_de_pol,
    input  logic            cfg_interlace,
    input  logic            cfg_vblank_osc,
    input  logic            cfg_hdmi_mode,
    output logic            hsync,
    output logic            vsync,
    output logic            de,
    output logic            field_id,
    output logic [PW-1:0]   pix_cnt,
    output logic [LW-1:0]   line_cnt,
    output logic            hdmi_mode
);
    logic [PW-1:0] hpos, half_pos;
    logic [LW-1:0] vpos;
    logic          h_idle, line_begin, half_hit, hs_act, h_in_act;
    logic          field, vs_act, v_in_act, de_act;
    logic [2:0]    lvl;

    vtg_line_fsm #(.HAW(HAW), .HSWW(HSWW)) u_line (
        .clk(clk), .rst_n(rst_n), .en(en),
        .h_active(cfg_h_active), .h_blank(cfg_h_blank),
        .h_sync_off(cfg_h_sync_off), .h_sync_wid(cfg_h_sync_wid),
        .hpos(hpos), .half_pos(half_pos), .h_idle(h_idle),
        .line_begin(line_begin), .half_hit(half_hit),
        .hs_act(hs_act), .h_in_act(h_in_act)
    );

    vtg_field_fsm #(.VAW(VAW), .VBW(VBW), .VSWW(VSWW), .PW(PW)) u_field (
        .clk(clk), .rst_n(rst_n), .en(en),
        .v_active(cfg_v_active), .v_blank(cfg_v_blank),
        .v_sync_off(cfg_v_sync_off), .v_sync_wid(cfg_v_sync_wid),
        .interlace(cfg_interlace), .osc(cfg_vblank_osc),
        .h_idle(h_idle), .line_begin(line_begin), .half_hit(half_hit),
        .hpos(hpos), .half_pos(half_pos),
        .vpos(vpos), .field(field), .vs_act(vs_act), .v_in_act(v_in_act)
    );

    assign de_act = h_in_act & v_in_act;

    vtg_polarity #(.N(3)) u_pol (
        .act({de_act, vs_act, hs_act}),
        .pol({cfg_de_pol, cfg_vs_pol, cfg_hs_pol}),
        .lvl(lvl)
    );

    assign hsync     = lvl[0];
    assign vsync     = lvl[1];
    assign de        = lvl[2];
    assign field_id  = field;
    assign pix_cnt   = hpos;
    assign line_cnt  = vpos;
    assign hdmi_mode = cfg_hdmi_mode;

    a_r4_de_region: assert property (@(posedge clk) disable iff (!rst_n)
        de_act |-> (hpos >= PW'(cfg_h_blank) &&
                    vpos >= LW'(cfg_v_blank) + LW'(cfg_interlace & cfg_vblank_osc & field)));
    a_r6_progressive: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_interlace && !field && line_begin) |=> !field);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!hs_act && !vs_act && !de_act));
endmodule

// File: tb/test_vid_timing_gen.sv
`timescale 1ns/1ps
module test_vid_timing_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [12:0] h_act, h_blk, h_off;
    logic [9:0]  h_wid;
    logic [12:0] v_act;
    logic [7:0]  v_blk, v_off;
    logic [5:0]  v_wid;
    logic hs_pol, vs_pol, de_pol, il, osc, hdmi;
    logic hsync, vsync, de, field_id, hdmi_o;
    logic [13:0] pix_cnt, line_cnt;

    int tests = 0, fails = 0;
    bit done = 0;
    int mh = 0, mv = 0, mf = 0;
    bit running = 0;
    int maxv [2];

    always #2.5 clk = ~clk;

    vid_timing_gen i_vid_timing_gen (
        .clk(clk), .rst_n(rst_n), .en(en),
        .cfg_h_active(h_act), .cfg_h_blank(h_blk), .cfg_h_sync_off(h_off),
        .cfg_h_sync_wid(h_wid), .cfg_v_active(v_act), .cfg_v_blank(v_blk),
        .cfg_v_sync_off(v_off), .cfg_v_sync_wid(v_wid),
        .cfg_hs_pol(hs_pol), .cfg_vs_pol(vs_pol), .cfg_de_pol(de_pol),
        .cfg_interlace(il), .cfg_vblank_osc(osc), .cfg_hdmi_mode(hdmi),
        .hsync(hsync), .vsync(vsync), .de(de), .field_id(field_id),
        .pix_cnt(pix_cnt), .line_cnt(line_cnt), .hdmi_mode(hdmi_o)
    );

    function automatic int htot();
        return int'(h_blk) + int'(h_act);
    endfunction
    function automatic int vb_of(int f);
        return int'(v_blk) + ((il && osc && f != 0) ? 1 : 0);
    endfunction
    function automatic bit lvl(bit a, bit p);
        return p ? a : !a;
    endfunction
    function automatic bit exp_vs();
        int idx, base;
        if (!running) return 1'b0;
        idx  = mv * htot() + mh;
        base = (mf != 0) ? htot() / 2 : 0;
        return idx >= int'(v_off) * htot() + base &&
               idx < (int'(v_off) + int'(v_wid)) * htot() + base;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        if (!en) begin
            running = 0; mh = 0; mv = 0; mf = 0;
        end else if (!running) begin
            running = 1; mh = 0; mv = 0; mf = 0;
        end else if (mh == htot() - 1) begin
            mh = 0;
            if (mv == vb_of(mf) + int'(v_act) - 1) begin
                mv = 0;
                mf = il ? 1 - mf : 0;
            end else mv++;
        end else mh++;
    endtask

    task automatic compare_all();
        bit hs_e, de_e;
        hs_e = running && mh >= int'(h_off) && mh < int'(h_off) + int'(h_wid);
        de_e = running && mh >= int'(h_blk) && mv >= vb_of(mf);
        chk("R2,R11", "pix_cnt", int'(pix_cnt), mh);
        chk("R2,R8", "line_cnt", int'(line_cnt), mv);
        chk("R6", "field_id", int'(field_id), mf);
        chk("R3,R9", "hsync", int'(hsync), int'(lvl(hs_e, hs_pol)));
        chk("R5,R7,R9", "vsync", int'(vsync), int'(lvl(exp_vs(), vs_pol)));
        chk("R4,R9", "de", int'(de), int'(lvl(de_e, de_pol)));
        chk("R10", "hdmi_mode", int'(hdmi_o), int'(hdmi));
        if (running && int'(line_cnt) > maxv[field_id]) maxv[field_id] = int'(line_cnt);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic stop_one();
        en = 1'b0;
        run(1);
    endtask

    task automatic frame_len(output int n);
        n = htot() * (2 * int'(v_blk) + 2 * int'(v_act) + 1);
    endtask

    initial begin
        int n, seed;
        seed = int'($urandom(32'd7321));
        h_act = 13'd8; h_blk = 13'd6; h_off = 13'd0; h_wid = 10'd2;
        v_act = 13'd4; v_blk = 8'd3; v_off = 8'd1; v_wid = 6'd1;
        hs_pol = 1'b0; vs_pol = 1'b1; de_pol = 1'b0;
        il = 1'b0; osc = 1'b1; hdmi = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "pix_cnt rst", int'(pix_cnt), 0);
        chk("R1", "line_cnt rst", int'(line_cnt), 0);
        chk("R1", "field rst", int'(field_id), 0);
        chk("R1", "hsync rst", int'(hsync), 1);
        chk("R1", "vsync rst", int'(vsync), 0);
        chk("R1", "de rst", int'(de), 1);
        rst_n = 1'b1;
        run(4);
        // progressive, sync offset 0, oscillation flag ignored (R8)
        en = 1'b1;
        maxv[0] = 0; maxv[1] = 0;
        frame_len(n);
        run(n);
        chk("R8", "prog max line", maxv[0], int'(v_blk) + int'(v_act) - 1);
        chk("R6", "prog field1 never", maxv[1], 0);
        // R11: drop enable mid-frame
        hdmi = 1'b0;
        run(37);
        stop_one();
        chk("R11", "pix after stop", int'(pix_cnt), 0);
        chk("R11", "line after stop", int'(line_cnt), 0);
        en = 1'b1;
        run(1);
        chk("R11", "restart pix", int'(pix_cnt), 0);
        run(50);
        stop_one();
        // interlaced with odd frame blanking (R7, R8)
        il = 1'b1; osc = 1'b1; v_blk = 8'd4; v_off = 8'd1; v_wid = 6'd2;
        h_act = 13'd9; h_blk = 13'd6; h_off = 13'd2; h_wid = 10'd3;
        hs_pol = 1'b1; vs_pol = 1'b0; de_pol = 1'b1;
        maxv[0] = 0; maxv[1] = 0;
        en = 1'b1;
        frame_len(n);
        run(2 * n);
        chk("R8", "field0 last line", maxv[0], int'(v_blk) + int'(v_act) - 1);
        chk("R8", "field1 last line", maxv[1], int'(v_blk) + int'(v_act));
        stop_one();
        // constrained random configurations
        for (int k = 0; k < 16; k++) begin
            h_blk  = 13'(3 + $urandom % 10);
            h_wid  = 10'(1 + $urandom % (int'(h_blk) / 2));
            h_off  = 13'($urandom % (int'(h_blk) - int'(h_wid) + 1));
            h_act  = 13'(1 + $urandom % 16);
            v_blk  = 8'(2 + $urandom % 8);
            v_wid  = 6'(1 + $urandom % (int'(v_blk) / 2));
            v_off  = 8'($urandom % (int'(v_blk) - int'(v_wid) + 1));
            v_act  = 13'(1 + $urandom % 8);
            hs_pol = 1'($urandom); vs_pol = 1'($urandom); de_pol = 1'($urandom);
            il     = 1'($urandom); osc = 1'($urandom); hdmi = 1'($urandom);
            en = 1'b1;
            frame_len(n);
            run(n + 40);
            stop_one();
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish act=0 exp=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule